// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the control strobes for the multiplexed external memory bus of an 8051-style core. It divides the oscillator clock into machine cycles of six states. Each state lasts two oscillator periods in normal mode and one period in double-speed mode. In every machine cycle it generates the address latch enable, the active-low program-store read strobe, the active-low data read and write strobes, the low-address/data bus value with its drive enable, and the high-address byte.

The core presents its request for the next machine cycle: an internal fetch, an external code fetch, an external data read or an external data write. It also presents the addressing width, the address, the port-2 latch value, the write data and an address-latch inhibit bit. The sequencer samples all of these on the last clock of the current machine cycle and holds them for the whole of the following one. The pin drivers, the memories and any wait-state stretching sit outside this block.

Top module: `xbus_strobe_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks when `dblSpeed` is 0 and 6 clocks when it is 1. It consists of six states, S1 to S6.
- R2: In internal-fetch and external-code cycles, `ale` is high during S1 and S4, which gives two pulses per cycle. When `aleInhibit` is clear, this makes `ale` a pulse train at one sixth (normal) or one third (double-speed) of the clock rate.
- R3: An external data read or write cycle gives exactly one `ale` pulse, in S1. `psenN` stays high for the whole of that cycle.
- R4: In an external-code cycle, `psenN` is low during S2–S3 and S5–S6, which gives two separate pulses. It is never low while `ale` is high.
- R5: `psenN` never goes low during an internal-fetch cycle.
- R6: When `aleInhibit` is sampled as 1, an internal-fetch cycle has no `ale` pulse. The bit has no effect on external-code or data cycles.
- R7: `addrHi` carries the upper address byte in external-code cycles and in data cycles with `wideAddr`=1. In data cycles with `wideAddr`=0, in internal-fetch cycles and in the idle cycle, it carries the sampled port-2 latch value.
- R8: In a read cycle `rdN` is low during S3–S5, and in a write cycle `wrN` is low during S3–S5. The two strobes are never low together, and neither is low while `ale` is high.
- R9: While `ale` is high, `adOe`=1 and `adOut` is the low address byte. While `wrN` is low, `adOe`=1 and `adOut` is the write data. At all other times, including while `rdN` is low, `adOe`=0 and `adOut`=0.
- R10: Reset (`rstN` low, asynchronous) puts the sequencer in S1 of an idle machine cycle. During reset and through that idle cycle, all strobes are inactive and `addrHi` is 8'hFF.
- R11: Requests are sampled only on the last clock of a machine cycle. Changes at any other time have no effect. Priority is write, then read, then external code, then internal fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dblSpeed | input | 1 | 1: one clock per state; 0: two clocks per state |
| fetchExt | input | 1 | Next cycle fetches code from external memory |
| dataRd | input | 1 | Next cycle is an external data read |
| dataWr | input | 1 | Next cycle is an external data write |
| wideAddr | input | 1 | Data access uses a 16-bit address |
| aleInhibit | input | 1 | Suppress address latch during internal fetches |
| addr | input | 16 | Address for the next cycle |
| p2Latch | input | 8 | Port-2 latch contents |
| wrData | input | 8 | Write data for the next cycle |
| ale | output | 1 | Address latch enable, active high |
| psenN | output | 1 | Program-store read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| adOut | output | 8 | Low-address/data bus value |
| adOe | output | 1 | Drive enable for the low-address/data bus |
| addrHi | output | 8 | High-address byte |

## Verification
The bound checker covers the relations that hold on every clock, whatever the request:
- the two data strobes never overlap;
- no strobe is active while the address latch is high;
- the program strobe stays off during data strobes;
- the bus is driven during the latch pulse and released during a read.

Only the bench scenarios can show the cycle-level behaviour. That means the state positions of each pulse, the pulse counts per access type in both speed modes, the inhibit acting on internal fetches alone, the high-address source, and requests being taken only at the cycle boundary with the right priority.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_INT,
    CYC_CODE,
    CYC_RD,
    CYC_WR
  } cyc_e;

  typedef struct packed {
    logic capture;     // last clock of a machine cycle: latch next request
    logic ale;
    logic psen;        // active high inside; inverted at the top
    logic rd;
    logic wr;
    logic hiFromAddr;  // high byte comes from the address, else port-2 latch
    logic drvAddr;
    logic drvData;
  } strobes_t;

endpackage

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_pkg::*;
#(
  parameter int STATES = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     dblSpeed,
  input  logic     fetchExt,
  input  logic     dataRd,
  input  logic     dataWr,
  input  logic     wideAddr,
  input  logic     aleInhibit,
  output strobes_t strb
);

  localparam int SW = $clog2(STATES);
  localparam logic [SW-1:0] SLOT_A = '0;
  localparam logic [SW-1:0] SLOT_B = SW'(STATES / 2);
  localparam logic [SW-1:0] WIN_LO = SW'(STATES / 2 - 1);
  localparam logic [SW-1:0] WIN_HI = SW'(STATES - 2);
  localparam logic [SW-1:0] LAST   = SW'(STATES - 1);

  logic [SW-1:0] stIdx;
  logic          phase;
  cyc_e          cyc, nextCyc;
  logic          inhQ, wideQ;
  logic          stepState, lastTick;

  assign stepState = dblSpeed | phase;
  assign lastTick  = (stIdx == LAST) & stepState;

  always_comb begin
    if (dataWr)        nextCyc = CYC_WR;
    else if (dataRd)   nextCyc = CYC_RD;
    else if (fetchExt) nextCyc = CYC_CODE;
    else               nextCyc = CYC_INT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stIdx <= '0;
      phase <= 1'b0;
      cyc   <= CYC_IDLE;
      inhQ  <= 1'b0;
      wideQ <= 1'b0;
    end else begin
      phase <= dblSpeed ? 1'b0 : ~phase;
      if (stepState) stIdx <= lastTick ? '0 : stIdx + 1'b1;
      if (lastTick) begin
        cyc   <= nextCyc;
        inhQ  <= aleInhibit;
        wideQ <= wideAddr;
      end
    end
  end

  logic inSlot, inSlotA, inWin;
  assign inSlotA = (stIdx == SLOT_A);
  assign inSlot  = inSlotA | (stIdx == SLOT_B);
  assign inWin   = (stIdx >= WIN_LO) & (stIdx <= WIN_HI);

  always_comb begin
    strb         = '0;
    strb.capture = lastTick;
    unique case (cyc)
      CYC_INT:  strb.ale = inSlot & ~inhQ;
      CYC_CODE: begin
        strb.ale  = inSlot;
        strb.psen = ~inSlot;
      end
      CYC_RD: begin
        strb.ale = inSlotA;
        strb.rd  = inWin;
      end
      CYC_WR: begin
        strb.ale = inSlotA;
        strb.wr  = inWin;
      end
      default: ;
    endcase
    strb.hiFromAddr = (cyc == CYC_CODE) | (((cyc == CYC_RD) | (cyc == CYC_WR)) & wideQ);
    strb.drvAddr    = strb.ale;
    strb.drvData    = strb.wr;
  end

endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] p2Latch,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] addrHi
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] p2Q, wdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      p2Q   <= '1;
      wdQ   <= '0;
    end else if (strb.capture) begin
      addrQ <= addr;
      p2Q   <= p2Latch;
      wdQ   <= wrData;
    end
  end

  always_comb begin
    if (strb.drvAddr)      adOut = addrQ[DATA_W-1:0];
    else if (strb.drvData) adOut = wdQ;
    else                   adOut = '0;
  end

  assign adOe   = strb.drvAddr | strb.drvData;
  assign addrHi = strb.hiFromAddr ? addrQ[ADDR_W-1:DATA_W] : p2Q;

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STATES = 6,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblSpeed,
  input  logic              fetchExt,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic              wideAddr,
  input  logic              aleInhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] p2Latch,
  input  logic [DATA_W-1:0] wrData,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] addrHi
);

  strobes_t strb;

  xbus_seq_ctrl #(.STATES(STATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .dblSpeed(dblSpeed), .fetchExt(fetchExt),
    .dataRd(dataRd), .dataWr(dataWr), .wideAddr(wideAddr),
    .aleInhibit(aleInhibit), .strb(strb)
  );

  xbus_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .p2Latch(p2Latch),
    .wrData(wrData), .adOut(adOut), .adOe(adOe), .addrHi(addrHi)
  );

  assign ale   = strb.ale;
  assign psenN = ~strb.psen;
  assign rdN   = ~strb.rd;
  assign wrN   = ~strb.wr;

endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic psenN,
  input logic rdN,
  input logic wrN,
  input logic adOe
);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(!rdN && !wrN));

  // R8
  data_vs_ale_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> (rdN && wrN));

  // R4
  psen_vs_ale_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> psenN);

  // R3
  data_no_psen_chk: assert property (@(posedge clk) disable iff (!rstN) (!rdN || !wrN) |-> psenN);

  // R9
  ale_drives_bus_chk: assert property (@(posedge clk) disable iff (!rstN) ale |-> adOe);

  // R9
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN) !rdN |-> !adOe);

endmodule

bind xbus_strobe_seq xbus_strobe_chk u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .adOe(adOe)
);

// File: tb/sim_xbus_strobe_seq.sv
`timescale 1ns/1ps
module sim_xbus_strobe_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dblSpeed = 1'b0, fetchExt = 1'b0, dataRd = 1'b0, dataWr = 1'b0;
  logic wideAddr = 1'b0, aleInhibit = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  p2Latch = 8'hFF, wrData = '0;
  logic ale, psenN, rdN, wrN, adOe;
  logic [7:0] adOut, addrHi;

  xbus_strobe_seq u0 (
    .clk(clk), .rstN(rstN), .dblSpeed(dblSpeed), .fetchExt(fetchExt),
    .dataRd(dataRd), .dataWr(dataWr), .wideAddr(wideAddr), .aleInhibit(aleInhibit),
    .addr(addr), .p2Latch(p2Latch), .wrData(wrData), .ale(ale), .psenN(psenN),
    .rdN(rdN), .wrN(wrN), .adOut(adOut), .adOe(adOe), .addrHi(addrHi)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 internal, 2 ext code, 3 read, 4 write
  int mT = 0, mType = 0, mPrevType = 0;
  bit mInh = 0, mWide = 0, mPrevInh = 0, mBoth = 0, mPrevBoth = 0;
  logic [15:0] mAddr = '0;
  logic [7:0]  mP2 = 8'hFF, mWd = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mT = 0; mType = 0; mPrevType = 0; mInh = 0; mWide = 0;
      mAddr = '0; mP2 = 8'hFF; mWd = '0; mBoth = 0;
    end else if (mT == (dblSpeed ? 5 : 11)) begin
      mPrevType = mType; mPrevInh = mInh; mPrevBoth = mBoth;
      mType = dataWr ? 4 : dataRd ? 3 : fetchExt ? 2 : 1;
      mBoth = dataWr && dataRd;
      mInh = aleInhibit; mWide = wideAddr;
      mAddr = addr; mP2 = p2Latch; mWd = wrData;
      mT = 0;
    end else mT++;
  end

  // per-cycle counters
  int cycClk = 0, cAle = 0, cPsen = 0, cRd = 0, cWr = 0;
  bit prevAle = 0, prevPsen = 1, fullCycle = 0, cycDbl = 0;

  task automatic checkCycle();
    int k;
    k = cycDbl ? 1 : 2;
    chk("R1 cycle length", cycClk, cycDbl ? 6 : 12);
    case (mPrevType)
      0: begin
        chk("R10 idle ale", cAle, 0); chk("R10 idle psen", cPsen, 0);
        chk("R10 idle rd", cRd, 0);   chk("R10 idle wr", cWr, 0);
      end
      1: begin
        chk(mPrevInh ? "R6 inhibited ale count" : "R2 internal ale count", cAle, mPrevInh ? 0 : 2);
        chk("R5 internal psen count", cPsen, 0);
      end
      2: begin
        chk(mPrevInh ? "R6 code ale count with inhibit" : "R2 code ale count", cAle, 2);
        chk("R4 code psen count", cPsen, 2);
      end
      3: begin
        chk("R3 read ale count", cAle, 1); chk("R3 read psen count", cPsen, 0);
        chk("R8 read rd clocks", cRd, 3 * k); chk("R8 read wr clocks", cWr, 0);
      end
      default: begin
        chk("R3 write ale count", cAle, 1); chk("R3 write psen count", cPsen, 0);
        chk(mPrevBoth ? "R11 priority wr clocks" : "R8 write wr clocks", cWr, 3 * k);
        chk(mPrevBoth ? "R11 priority rd clocks" : "R8 write rd clocks", cRd, 0);
      end
    endcase
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      fullCycle = 0; cycClk = 0; cAle = 0; cPsen = 0; cRd = 0; cWr = 0;
      prevAle = 0; prevPsen = 1;
    end else begin
      int s;
      bit eAle, ePsen, eRd, eWr;
      string tA, tP, tS, tD, tH;
      if (mT == 0) begin
        if (fullCycle) checkCycle();
        fullCycle = 1;
        cycClk = 0; cAle = 0; cPsen = 0; cRd = 0; cWr = 0;
      end
      if (mT == 1) cycDbl = dblSpeed;
      cycClk++;
      if (ale && !prevAle) cAle++;
      if (!psenN && prevPsen) cPsen++;
      if (!rdN) cRd++;
      if (!wrN) cWr++;
      prevAle = ale; prevPsen = psenN;

      s = dblSpeed ? mT : mT / 2;
      eAle = 0; ePsen = 0; eRd = 0; eWr = 0;
      case (mType)
        1: eAle = (s == 0 || s == 3) && !mInh;
        2: begin eAle = (s == 0 || s == 3); ePsen = !eAle; end
        3: begin eAle = (s == 0); eRd = (s >= 2 && s <= 4); end
        4: begin eAle = (s == 0); eWr = (s >= 2 && s <= 4); end
        default: ;
      endcase
      tA = mType == 0 ? "R10 ale" : mType == 1 ? (mInh ? "R6 ale" : "R2 ale") :
           mType == 2 ? "R2 ale" : "R3 ale";
      tP = mType == 0 ? "R10 psenN" : mType == 1 ? "R5 psenN" : mType == 2 ? "R4 psenN" : "R3 psenN";
      tS = mType == 0 ? "R10 strobe" : "R8 strobe";
      tD = mType == 0 ? "R10 bus" : "R9 bus";
      tH = mType == 0 ? "R10 addrHi" : "R7 addrHi";
      chk(tA, int'(ale), int'(eAle));
      chk(tP, int'(psenN), int'(!ePsen));
      chk(tS, int'(rdN), int'(!eRd));
      chk(tS, int'(wrN), int'(!eWr));
      chk(tD, int'(adOe), int'(eAle || eWr));
      chk(tD, int'(adOut), eAle ? int'(mAddr[7:0]) : eWr ? int'(mWd) : 0);
      chk(tH, int'(addrHi),
          (mType == 2 || ((mType == 3 || mType == 4) && mWide)) ? int'(mAddr[15:8]) : int'(mP2));
    end
  end

  bit modeDbl = 0;

  task automatic waitStart();
    do @(negedge clk); while (mT != 0);
    #1;
  endtask

  task automatic setReq(int ty, bit inh, bit wide, logic [15:0] a, logic [7:0] p2, logic [7:0] wd);
    dblSpeed = modeDbl;
    fetchExt = (ty == 2);
    dataRd = (ty == 3 || ty == 5);
    dataWr = (ty == 4 || ty == 5);
    aleInhibit = inh; wideAddr = wide;
    addr = a; p2Latch = p2; wrData = wd;
  endtask

  task automatic issue(int ty, bit inh, bit wide, logic [15:0] a, logic [7:0] p2, logic [7:0] wd);
    waitStart();
    setReq(ty, inh, wide, a, p2, wd);
  endtask

  // R11: a request present mid-cycle is replaced before the boundary
  task automatic issueWiggle(logic [15:0] a);
    waitStart();
    setReq(3, 1, 0, 16'h0F0F, 8'h11, 8'h22);
    do @(negedge clk); while (mT != 3);
    #1;
    setReq(5, 0, 1, a, 8'h33, 8'h5A);
  endtask

  task automatic runMode(bit d);
    modeDbl = d;
    issue(1, 0, 0, 16'h1234, 8'hA5, 8'h00);
    issue(1, 1, 1, 16'h4321, 8'h3C, 8'h00);
    issue(2, 1, 0, 16'hBEEF, 8'h77, 8'h00);
    issue(2, 0, 0, 16'h8001, 8'h66, 8'h00);
    issue(3, 0, 1, 16'hC0DE, 8'h99, 8'h00);
    issue(3, 0, 0, 16'h7E81, 8'h42, 8'h00);
    issue(4, 0, 1, 16'hF00D, 8'h24, 8'hC3);
    issue(4, 0, 0, 16'h00AA, 8'h81, 8'h3C);
    issueWiggle(16'hABCD);
    issue(1, 0, 0, 16'h2468, 8'hE7, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs while reset is held
    chk("R10 reset ale", int'(ale), 0);
    chk("R10 reset psenN", int'(psenN), 1);
    chk("R10 reset rdN", int'(rdN), 1);
    chk("R10 reset wrN", int'(wrN), 1);
    chk("R10 reset adOe", int'(adOe), 0);
    chk("R10 reset addrHi", int'(addrHi), 8'hFF);
    #1 rstN = 1'b1;
    runMode(0);
    runMode(1);
    runMode(0);
    waitStart();
    waitStart();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at %0t: actual hung expected finished", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule